// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital front end of a four-channel, 16-bit converter. A host sends 24-bit command frames over a serial link framed by an active-low select line. The block samples the serial lines and strobes into its own system clock and decodes each completed frame. A write command loads the addressed channel's input register.

Each input register has a matching DAC register, and the DAC register values drive the converter. The level of the active-low load strobe picks one of two update modes. With the strobe low, the addressed DAC register takes the new word as soon as the 24th bit arrives. With the strobe high, only the input register changes. A later falling edge of the strobe then copies all four input registers into the DAC registers in the same clock cycle.

An active-low clear input forces every DAC register to zero. A serial output presents the top bit of the shift register so that several devices can be chained.

Top module: `quad_dac_frontend`

## Requirements
- R1: After the synchronous active-high reset, all four DAC outputs read 0x0000 and `sdo` is 0.
- R2: While `sync_n` is low, `sdin` is sampled MSB first on each falling edge of `sclk`. The frame fields are as follows:
  - bits 23:21: command (000 means write)
  - bits 20:19: channel number (00 selects channel 0, up to 11 for channel 3)
  - bits 18:16: reserved and ignored
  - bits 15:0: data word
- R2 (continued): Channel n appears on `dac_flat[16n+15:16n]`.
- R3: If a write frame completes while `ldac_n` is low, the addressed channel's DAC output takes the data word. The other channels are unchanged.
- R4: If a write frame completes while `ldac_n` is high, no DAC output changes.
- R5: A falling edge on `ldac_n` copies all four input registers into the DAC registers at once.
- R6: While `clr_n` is low, every DAC output reads 0x0000. The input registers keep their contents, so a later `ldac_n` falling edge restores them.
- R7: If `sync_n` rises after fewer than 24 falling `sclk` edges, no register changes. This holds even when 23 bits were received.
- R8: `sdo` shows bit 23 of the shift register and changes only on rising `sclk` edges. During the next frame, the bits of the previous frame appear MSB first, one bit before each falling edge.
- R9: A completed frame whose command field is not 000 changes no input register and no DAC output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sdin | input | 1 | Serial data in |
| clr_n | input | 1 | Active-low clear of all DAC registers |
| ldac_n | input | 1 | Active-low load strobe, level selects the update mode |
| sdo | output | 1 | Serial data out for chaining |
| dac_flat | output | 64 | Four 16-bit DAC register values, channel 0 in the low bits |

## Verification
Every pin passes through a two-stage synchronizer. A DAC output therefore changes four clock cycles after the 24th falling `sclk` edge at the pin: two synchronizer stages, one edge-detect and shift register, and one register-bank update. An `ldac_n` falling edge or a `clr_n` assertion reaches the outputs after three cycles, and `sdo` follows a rising `sclk` after three cycles. The bench holds every serial-clock phase for at least six system cycles and waits at least eight cycles after each strobe change. It samples only after those windows have passed, one time unit after a rising clock edge. Its reference model of the input and DAC registers is updated directly from the requirements when each frame or strobe change is driven.

// File: rtl/qdf_pkg.sv
package qdf_pkg;
  localparam int NCH_DEF    = 4;
  localparam int DATA_W_DEF = 16;
  localparam int RSV_W_DEF  = 3;
  localparam int CMD_W_DEF  = 3;
  localparam int STAGES_DEF = 2;
  localparam logic [CMD_W_DEF-1:0] CMD_WRITE_DEF = 3'b000;
endpackage

// File: rtl/qdf_sync.sv
module qdf_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdf_shift.sv
module qdf_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_s,
  input  logic               sclk_s,
  input  logic               sdin_s,
  output logic [FRAME_W-1:0] word,
  output logic               word_vld,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic             sclk_d;
  logic             fall, rise;
  logic [CNT_W-1:0] cnt;

  assign fall = sclk_d & ~sclk_s;
  assign rise = ~sclk_d & sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      word     <= '0;
      cnt      <= '0;
      word_vld <= 1'b0;
      sdo      <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      word_vld <= 1'b0;
      if (sync_s) begin
        cnt <= '0;
      end else if (fall) begin
        word <= {word[FRAME_W-2:0], sdin_s};
        if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(FRAME_W - 1)) word_vld <= 1'b1;
      end
      if (rise) sdo <= word[FRAME_W-1];
    end
  end

  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    sync_s |=> !word_vld); // R7
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld); // R2
  AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !(sclk_s && !sclk_d) |=> $stable(sdo)); // R8
endmodule

// File: rtl/qdf_regbank.sv
module qdf_regbank #(
  parameter int NCH = 4,
  parameter int DATA_W = 16,
  parameter int RSV_W = 3,
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] CMD_WRITE = '0,
  localparam int ADDR_W = $clog2(NCH),
  localparam int FRAME_W = CMD_W + ADDR_W + RSV_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAME_W-1:0]    word,
  input  logic                  word_vld,
  input  logic                  ldac_s,
  input  logic                  clr_s,
  output logic [NCH*DATA_W-1:0] dac_flat
);
  logic [DATA_W-1:0] in_reg [NCH];
  logic [DATA_W-1:0] in_nxt [NCH];
  logic [DATA_W-1:0] dac_reg [NCH];
  logic [NCH*DATA_W-1:0] in_flat;

  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              unused_rsv;
  logic              ldac_d, ldac_fall, wr;

  assign data       = word[DATA_W-1:0];
  assign addr       = word[DATA_W+RSV_W +: ADDR_W];
  assign cmd        = word[FRAME_W-1 -: CMD_W];
  assign unused_rsv = ^word[DATA_W +: RSV_W];
  assign wr         = word_vld && (cmd == CMD_WRITE);
  assign ldac_fall  = ldac_d & ~ldac_s;

  always_comb begin
    for (int i = 0; i < NCH; i++) in_nxt[i] = in_reg[i];
    if (wr) in_nxt[addr] = data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldac_d <= 1'b1;
      for (int i = 0; i < NCH; i++) in_reg[i] <= '0;
    end else begin
      ldac_d <= ldac_s;
      for (int i = 0; i < NCH; i++) in_reg[i] <= in_nxt[i];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || !clr_s)
        dac_reg[c] <= '0;
      else if (ldac_fall)
        dac_reg[c] <= in_nxt[c];
      else if (wr && !ldac_s && addr == ADDR_W'(c))
        dac_reg[c] <= data;
    end
    assign dac_flat[c*DATA_W +: DATA_W] = dac_reg[c];
    assign in_flat[c*DATA_W +: DATA_W]  = in_reg[c];

    AST_AUTO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (wr && addr == ADDR_W'(c) && !ldac_s && clr_s) |=> dac_reg[c] == $past(data)); // R3
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> dac_flat == '0); // R6
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (clr_s && ldac_s) |=> $stable(dac_flat)); // R4
  AST_BROADCAST: assert property (@(posedge clk) disable iff (rst)
    (ldac_fall && clr_s && !wr) |=> dac_flat == $past(in_flat)); // R5
  AST_CMD_FILTER: assert property (@(posedge clk) disable iff (rst)
    (word_vld && cmd != CMD_WRITE) |=> $stable(in_flat)); // R9
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
  import qdf_pkg::*;
#(
  parameter int NCH = NCH_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int RSV_W = RSV_W_DEF,
  parameter int CMD_W = CMD_W_DEF,
  parameter int STAGES = STAGES_DEF,
  parameter logic [CMD_W-1:0] CMD_WRITE = CMD_WRITE_DEF,
  localparam int ADDR_W = $clog2(NCH),
  localparam int FRAME_W = CMD_W + ADDR_W + RSV_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync_n,
  input  logic                  sclk,
  input  logic                  sdin,
  input  logic                  clr_n,
  input  logic                  ldac_n,
  output logic                  sdo,
  output logic [NCH*DATA_W-1:0] dac_flat
);
  logic [4:0] pins_s;
  logic [FRAME_W-1:0] word;
  logic word_vld;

  qdf_sync #(.W(5), .STAGES(STAGES), .RST_VAL(5'b11111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sync_n, sclk, sdin, clr_n, ldac_n}),
    .q   (pins_s)
  );

  qdf_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .sync_s   (pins_s[4]),
    .sclk_s   (pins_s[3]),
    .sdin_s   (pins_s[2]),
    .word     (word),
    .word_vld (word_vld),
    .sdo      (sdo)
  );

  qdf_regbank #(
    .NCH(NCH), .DATA_W(DATA_W), .RSV_W(RSV_W),
    .CMD_W(CMD_W), .CMD_WRITE(CMD_WRITE)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .word     (word),
    .word_vld (word_vld),
    .ldac_s   (pins_s[0]),
    .clr_s    (pins_s[1]),
    .dac_flat (dac_flat)
  );
endmodule

// File: tb/quad_dac_frontend_tb.sv
`timescale 1ns/1ps
module quad_dac_frontend_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b1, clr_n = 1'b1, ldac_n = 1'b0;
  logic sdo;
  logic [63:0] dac_flat;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m_in [4];
  logic [15:0] m_dac [4];

  // {ldac level, frame}: frame = cmd[23:21] addr[20:19] rsv[18:16] data[15:0]
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 24'h00_1111}, {1'b0, 24'h08_2222}, {1'b0, 24'h10_3333},
    {1'b0, 24'h18_4444}, {1'b1, 24'h00_AAAA}, {1'b1, 24'h0F_BBBB},
    {1'b0, 24'h20_5555}, {1'b0, 24'h17_CCCC}
  };

  always #5 clk = ~clk;

  quad_dac_frontend u_dut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .clr_n(clr_n), .ldac_n(ldac_n), .sdo(sdo), .dac_flat(dac_flat)
  );

  function automatic logic [63:0] model_flat();
    logic [63:0] v;
    for (int i = 0; i < 4; i++) v[i*16 +: 16] = m_dac[i];
    return v;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_ldac(input logic lvl);
    if (ldac_n === 1'b1 && lvl === 1'b0 && clr_n === 1'b1)
      for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    ldac_n = lvl;
    tick(8);
  endtask

  task automatic send(input logic [23:0] f, input int nbits, input bit chk_sdo,
                      input logic [23:0] prev, output int sdo_err);
    sdo_err = 0;
    sync_n = 1'b0;
    tick(6);
    for (int i = 0; i < nbits; i++) begin
      sdin = f[23-i];
      tick(3);
      if (chk_sdo && sdo !== prev[23-i]) sdo_err++;
      sclk = 1'b0;
      tick(6);
      sclk = 1'b1;
      tick(3);
    end
    sync_n = 1'b1;
    sdin = 1'b1;
    tick(10);
  endtask

  task automatic write_frame(input logic [23:0] f);
    int e;
    send(f, 24, 1'b0, 24'h0, e);
    if (f[23:21] == 3'b000) begin
      m_in[f[20:19]] = f[15:0];
      if (ldac_n === 1'b0 && clr_n === 1'b1) m_dac[f[20:19]] = f[15:0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e;
    for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    tick(4);
    rst = 1'b0;
    tick(4);
    chk("R1 reset dac", dac_flat, 64'h0);
    chk("R1 reset sdo", {63'h0, sdo}, 64'h0);

    // Table walk: R2 decode with R3 auto, R4 hold, R5 on strobe fall, R9 filter
    for (int v = 0; v < 8; v++) begin
      logic lv_prev;
      lv_prev = ldac_n;
      set_ldac(VEC[v][24]);
      if (lv_prev === 1'b1 && VEC[v][24] === 1'b0)
        chk("R5 strobe fall in table", dac_flat, model_flat());
      write_frame(VEC[v][23:0]);
      if (VEC[v][23:21] != 3'b000)      chk("R9 non-write ignored", dac_flat, model_flat());
      else if (VEC[v][24])              chk("R2 R4 held write", dac_flat, model_flat());
      else                              chk("R2 R3 auto write", dac_flat, model_flat());
    end

    // R4 then R5: hold a write to channel 3, then release all together
    set_ldac(1'b1);
    write_frame(24'h18_7777);
    chk("R4 held ch3", dac_flat, model_flat());
    set_ldac(1'b0);
    chk("R5 all channels copied", dac_flat, model_flat());

    // R6: clear forces zero, input registers retained
    clr_n = 1'b0;
    tick(8);
    for (int i = 0; i < 4; i++) m_dac[i] = '0;
    chk("R6 clear zero", dac_flat, 64'h0);
    clr_n = 1'b1;
    tick(8);
    chk("R6 stays zero after release", dac_flat, 64'h0);
    set_ldac(1'b1);
    set_ldac(1'b0);
    chk("R6 inputs retained", dac_flat, model_flat());

    // R7: aborted frames of 10 and 23 bits
    send(24'h00_9999, 10, 1'b0, 24'h0, e);
    chk("R7 10-bit abort", dac_flat, model_flat());
    send(24'h08_8888, 23, 1'b0, 24'h0, e);
    chk("R7 23-bit abort", dac_flat, model_flat());
    set_ldac(1'b1);
    set_ldac(1'b0);
    chk("R7 inputs untouched", dac_flat, model_flat());

    // R8: previous frame emerges on sdo during the next frame
    write_frame(24'h3C_A5A5);
    send(24'hE0_0000, 24, 1'b1, 24'h3C_A5A5, e);
    chk("R8 sdo chain mismatches", 64'(e), 64'h0);
    chk("R9 chain frames ignored", dac_flat, model_flat());

    // R1: reset in mid-run
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(3);
    chk("R1 reset again", dac_flat, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule